// File: doc/BRIEF.md
# Heartbeat and Retransmit Interval Timers

This block holds two register-programmed down-counting interval timers for a management controller. The heartbeat timer runs freely once enabled. Each time it expires it raises a request to send a periodic status packet, and then it reloads itself. The retransmit timer sits idle until an alert begins. It then paces a burst of repeated packet sends: one request at once, then one each time its interval runs out, until the requested number of sends has been issued.

Software reaches both timers through a byte-wide register port with a one-bit address and a single-cycle write strobe. Reads are combinational. Each timer counts in units of its own external tick input, which a prescaler elsewhere provides. The heartbeat unit is the coarse one, about four times the retransmit unit. Both request outputs are single-cycle pulses, registered one clock after their cause.

Top module: `mgmt_interval_timers`

## Requirements
- R1: After reset, both registers read 02h (heartbeat load 1, disabled; retransmit load 1), and neither request output is high.
- R2: Register address 0 is the heartbeat register and address 1 the retransmit register. Bits 7:1 hold a 7-bit value, and bit 0 of the heartbeat register is its enable. While the heartbeat timer is disabled its register reads back the load value with bit 0 low. While it is enabled it reads back the live count in bits 7:1 with bit 0 high.
- R3: A heartbeat write made while the timer is enabled leaves the load value unchanged, but the enable bit still takes the written bit 0. Writing bit 0 high while enabled restarts the count from the unchanged load value.
- R4: A single heartbeat write made while the timer is disabled can set a new load value and bit 0 high together. The count then starts from the new value at once.
- R5: An enabled heartbeat timer decrements only on cycles with `hb_tick` high. A tick that finds the count at 1 (or 0) is an expiry: the count reloads from the load value, and `hb_req` is high for the next cycle only. `rt_tick` has no effect on it.
- R6: Neither timer emits a request while its load value is zero.
- R7: The retransmit load value accepts every write. Its register always reads back the load value with bit 0 low, whatever is written to bit 0.
- R8: An `alert_start` pulse with `alert_count` = N (N > 0) and a nonzero load value L raises `rt_req` on the next cycle. After that the timer raises `rt_req` once per L `rt_tick` cycles until N requests have been issued in total, and then it stops.
- R9: A retransmit load value written during an active sequence leaves the current countdown alone and sets the interval from the next reload onward.
- R10: When a heartbeat expiry and a heartbeat register write fall in the same cycle, the register state follows the write, and the expiry pulse on `hb_req` is still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register address: 0 heartbeat, 1 retransmit |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for the selected register |
| hb_tick | input | 1 | Heartbeat time-unit tick |
| rt_tick | input | 1 | Retransmit time-unit tick |
| alert_start | input | 1 | Starts a retransmit sequence |
| alert_count | input | CNT_W (4) | Total number of retransmit requests for the sequence |
| hb_req | output | 1 | Heartbeat request pulse |
| rt_req | output | 1 | Retransmit request pulse |

## Verification
The collision that matters is a heartbeat expiry and a heartbeat register write in the same clock. The bench drives `hb_tick` high, while the count stands at 1, in the very cycle that it writes a disable. It then checks two results: a pulse appears on `hb_req`, and the register reads back disabled with the old load value. A second overlap happens when a retransmit load write lands in the middle of a countdown. That case is judged by counting ticks: the next request comes on the old schedule, and the one after follows the new interval.

// File: rtl/mit_pkg.sv
package mit_pkg;

    localparam int VAL_W = 7;
    localparam int REG_W = VAL_W + 1;

    typedef logic [VAL_W-1:0] ival_t;

    localparam ival_t VAL_RST = ival_t'(1);

    typedef enum logic {
        SEL_HB = 1'b0,
        SEL_RT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        ival_t    val;
        logic     ctl;
    } reg_wr_t;

    function automatic logic expires(ival_t c);
        return c <= ival_t'(1);
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(ival_t v, logic b);
        return {v, b};
    endfunction

endpackage

// File: rtl/mit_hb_timer.sv
module mit_hb_timer
    import mit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ival_t            wr_val,
    input  logic             wr_ctl,
    input  logic             tick,
    output logic             req,
    output logic [REG_W-1:0] rdata
);

    ival_t load_q;
    ival_t cnt_q;
    logic  en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= VAL_RST;
            cnt_q  <= VAL_RST;
            en_q   <= 1'b0;
            req    <= 1'b0;
        end else begin
            req <= 1'b0;
            if (en_q && tick) begin
                if (expires(cnt_q)) begin
                    cnt_q <= load_q;
                    req   <= (load_q != '0);
                end else begin
                    cnt_q <= cnt_q - ival_t'(1);
                end
            end
            // register write overrides the countdown update
            if (wr_en) begin
                en_q <= wr_ctl;
                if (!en_q) load_q <= wr_val;
                if (wr_ctl) cnt_q <= en_q ? load_q : wr_val;
            end
        end
    end

    assign rdata = en_q ? pack_reg(cnt_q, 1'b1) : pack_reg(load_q, 1'b0);

    p_hb_load_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(load_q));

    p_hb_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(en_q && tick));

    p_hb_no_req_zero_r6: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(load_q != '0));

endmodule

// File: rtl/mit_rt_timer.sv
module mit_rt_timer
    import mit_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ival_t            wr_val,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    output logic             req,
    output logic [REG_W-1:0] rdata
);

    ival_t            load_q;
    ival_t            cnt_q;
    logic [CNT_W-1:0] left_q;
    logic             active;

    assign active = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= VAL_RST;
            cnt_q  <= VAL_RST;
            left_q <= '0;
            req    <= 1'b0;
        end else begin
            req <= 1'b0;
            if (start) begin
                if (load_q != '0 && start_cnt != '0) begin
                    req    <= 1'b1;
                    left_q <= start_cnt - 1'b1;
                    cnt_q  <= load_q;
                end else begin
                    left_q <= '0;
                end
            end else if (active && tick) begin
                if (expires(cnt_q)) begin
                    cnt_q <= load_q;
                    if (load_q != '0) begin
                        req    <= 1'b1;
                        left_q <= left_q - 1'b1;
                    end else begin
                        left_q <= '0;
                    end
                end else begin
                    cnt_q <= cnt_q - ival_t'(1);
                end
            end
            if (wr_en) load_q <= wr_val;
        end
    end

    assign rdata = pack_reg(load_q, 1'b0);

    p_rt_req_cause_r8: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(start || (tick && active)));

    p_rt_left_no_grow_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> left_q <= $past(left_q));

    p_rt_no_req_zero_r6: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(load_q != '0));

    p_rt_count_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (!start && active && tick && cnt_q > ival_t'(1)) |=> cnt_q == $past(cnt_q) - ival_t'(1));

endmodule

// File: rtl/mgmt_interval_timers.sv
module mgmt_interval_timers
    import mit_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             hb_tick,
    input  logic             rt_tick,
    input  logic             alert_start,
    input  logic [CNT_W-1:0] alert_count,
    output logic             hb_req,
    output logic             rt_req
);

    reg_wr_t          wcmd;
    logic [REG_W-1:0] hb_rdata;
    logic [REG_W-1:0] rt_rdata;

    assign wcmd = '{wr: reg_wr, sel: reg_sel_e'(reg_sel),
                    val: reg_wdata[REG_W-1:1], ctl: reg_wdata[0]};

    mit_hb_timer u_hb (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wcmd.wr && wcmd.sel == SEL_HB),
        .wr_val (wcmd.val),
        .wr_ctl (wcmd.ctl),
        .tick   (hb_tick),
        .req    (hb_req),
        .rdata  (hb_rdata)
    );

    mit_rt_timer #(.CNT_W(CNT_W)) u_rt (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wcmd.wr && wcmd.sel == SEL_RT),
        .wr_val    (wcmd.val),
        .tick      (rt_tick),
        .start     (alert_start),
        .start_cnt (alert_count),
        .req       (rt_req),
        .rdata     (rt_rdata)
    );

    assign reg_rdata = (wcmd.sel == SEL_HB) ? hb_rdata : rt_rdata;

    p_req_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!hb_req && !rt_req));

endmodule

// File: tb/sim_mgmt_interval_timers.sv
`timescale 1ns/1ps
module sim_mgmt_interval_timers;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       hb_tick = 1'b0;
    logic       rt_tick = 1'b0;
    logic       alert_start = 1'b0;
    logic [3:0] alert_count = 4'd0;
    logic       hb_req;
    logic       rt_req;

    int total = 0;
    int bad = 0;
    int nh = 0;
    int nr = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    mgmt_interval_timers #(.CNT_W(4)) u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hb_tick(hb_tick),
        .rt_tick(rt_tick), .alert_start(alert_start), .alert_count(alert_count),
        .hb_req(hb_req), .rt_req(rt_req)
    );

    // {sel, write data, expected read-back}
    localparam logic [16:0] TBL [9] = '{
        {1'b0, 8'h14, 8'h14},   // R2 disabled load write
        {1'b0, 8'h06, 8'h06},
        {1'b1, 8'h0A, 8'h0A},   // R7
        {1'b1, 8'h0B, 8'h0A},   // R7 bit 0 reserved
        {1'b0, 8'h21, 8'h21},   // R4 load+enable together
        {1'b0, 8'h41, 8'h21},   // R3 load ignored, restart
        {1'b0, 8'h40, 8'h20},   // R3 disable, load kept
        {1'b0, 8'h40, 8'h40},   // R2 disabled again, load taken
        {1'b1, 8'h02, 8'h02}    // R7
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic ht, input logic rtt, input logic ast,
                        input logic [3:0] acnt, input logic wr,
                        input logic sel, input logic [7:0] wd);
        @(negedge clk);
        hb_tick = ht; rt_tick = rtt; alert_start = ast; alert_count = acnt;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(negedge clk);
        nh = int'(hb_req); nr = int'(rt_req);
        hb_tick = 1'b0; rt_tick = 1'b0; alert_start = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wreg(input logic sel, input logic [7:0] wd);
        step(1'b0, 1'b0, 1'b0, 4'd0, 1'b1, sel, wd);
    endtask

    task automatic tk(input logic ht, input logic rtt);
        step(ht, rtt, 1'b0, 4'd0, 1'b0, reg_sel, 8'h00);
    endtask

    task automatic rd(input logic sel);
        @(negedge clk);
        reg_sel = sel;
        #1 rv = reg_rdata;
    endtask

    initial begin
        // R1 reset state
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 hb_req", int'(hb_req), 0);
        chk("R1 rt_req", int'(rt_req), 0);
        rd(1'b0); chk("R1 hb reg", int'(rv), 8'h02);
        rd(1'b1); chk("R1 rt reg", int'(rv), 8'h02);

        // R2 R3 R4 R7 table walk
        for (int i = 0; i < 9; i++) begin
            wreg(TBL[i][16], TBL[i][15:8]);
            rd(TBL[i][16]);
            chk($sformatf("R2/R3/R4/R7 vec %0d", i), int'(rv), int'(TBL[i][7:0]));
        end

        // R5 periodic heartbeat, load 3
        wreg(1'b0, 8'h07);
        rd(1'b0); chk("R4 start count", int'(rv), 8'h07);
        tk(1'b1, 1'b0); chk("R5 no early req", nh, 0);
        rd(1'b0); chk("R5 count 2", int'(rv), 8'h05);
        for (int i = 0; i < 3; i++) begin
            tk(1'b0, 1'b1); chk("R5 rt_tick ignored", nh, 0);
        end
        rd(1'b0); chk("R5 count held", int'(rv), 8'h05);
        tk(1'b1, 1'b0); chk("R5 no req at 1", nh, 0);
        rd(1'b0); chk("R5 count 1", int'(rv), 8'h03);
        tk(1'b1, 1'b0); chk("R5 expiry req", nh, 1);
        rd(1'b0); chk("R5 reload", int'(rv), 8'h07);
        tk(1'b0, 1'b0); chk("R5 single pulse", nh, 0);
        for (int i = 0; i < 3; i++) begin
            tk(1'b1, 1'b0); chk("R5 second period", nh, (i == 2) ? 1 : 0);
        end

        // R10 expiry and write in same cycle
        tk(1'b1, 1'b0); tk(1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 8'h00);
        chk("R10 pulse kept", nh, 1);
        rd(1'b0); chk("R10 write wins", int'(rv), 8'h06);

        // R6 heartbeat zero load
        wreg(1'b0, 8'h01);
        rd(1'b0); chk("R6 hb zero enabled", int'(rv), 8'h01);
        begin
            int s = 0;
            for (int i = 0; i < 5; i++) begin tk(1'b1, 1'b0); s += nh; end
            chk("R6 hb no req", s, 0);
        end
        wreg(1'b0, 8'h00);

        // R8 retransmit sequence, load 3, N=3
        wreg(1'b1, 8'h06);
        step(1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1, 8'h00);
        chk("R8 immediate req", nr, 1);
        begin
            int s = 1;
            for (int i = 0; i < 12; i++) begin
                tk(1'b1, 1'b1);
                chk("R8 pacing", nr, (i == 2 || i == 5) ? 1 : 0);
                s += nr;
            end
            chk("R8 total", s, 3);
        end

        // R9 load change mid-sequence
        step(1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1, 8'h00);
        chk("R9 start req", nr, 1);
        tk(1'b0, 1'b1); chk("R9 tick1", nr, 0);
        wreg(1'b1, 8'h0A);
        rd(1'b1); chk("R9 new load read", int'(rv), 8'h0A);
        tk(1'b0, 1'b1); chk("R9 old count", nr, 0);
        tk(1'b0, 1'b1); chk("R9 old schedule req", nr, 1);
        for (int i = 0; i < 5; i++) begin
            tk(1'b0, 1'b1); chk("R9 new interval", nr, (i == 4) ? 1 : 0);
        end
        begin
            int s = 0;
            for (int i = 0; i < 6; i++) begin tk(1'b0, 1'b1); s += nr; end
            chk("R9 sequence done", s, 0);
        end

        // R6 retransmit zero load
        wreg(1'b1, 8'h00);
        step(1'b0, 1'b0, 1'b1, 4'd2, 1'b0, 1'b1, 8'h00);
        chk("R6 rt no start req", nr, 0);
        begin
            int s = 0;
            for (int i = 0; i < 4; i++) begin tk(1'b0, 1'b1); s += nr; end
            chk("R6 rt no req", s, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule